// File: doc/BRIEF.md
# Latched Conversion Result Byte Read Port

This block holds the most recent conversion result and lets a host read it over a byte-wide parallel bus. The result is a magnitude of 12 bits plus a sign flag and an over-range flag. A strobe from the conversion sequencer copies the result into a holding register. Outside that strobe the holding register never changes, so a host read that spans several cycles always sees one coherent word.

The held word is split into two byte lanes. The low lane carries the eight least significant magnitude bits. The high lane carries the remaining magnitude bits, then the over-range flag, then the sign flag, with its spare upper bits driven to zero.

Each lane drives only when three conditions hold: the port is in direct-read mode (mode input low), the shared chip select is low, and that lane's own select is low. Any other combination turns the lane's drive off. The tri-state pad is modelled as a per-lane output enable, and the bus value is forced to zero while the lane is not driving. At the pads, the select inputs carry pull-ups, so an open pin reads as inactive. The core treats only a definite low as asserted.

Top module: `rbp_read_port`

## Requirements
- R1: Reset clears the held result, so that a read straight after reset returns zero on both lanes.
- R2: When `res_load` is high at a rising clock edge, the held result takes the value of `res_mag`, `res_neg` and `res_over`. The new value is visible on the lanes after that edge and not before it.
- R3: While `res_load` is low, the held result does not change, whatever `res_mag`, `res_neg` and `res_over` do.
- R4: While `lo_drive` is high, `lo_bus[7:0]` equals held magnitude bits [7:0].
- R5: While `hi_drive` is high, `hi_bus` carries the following fields:
  - bits [3:0] hold held magnitude bits [11:8];
  - bit 4 holds the over-range flag;
  - bit 5 holds the sign flag;
  - bits [7:6] are zero.
- R6: `lo_drive` is high exactly when `mode_hs`, `cs_n` and `lo_en_n` are all low. `hi_drive` is high exactly when `mode_hs`, `cs_n` and `hi_en_n` are all low. The two lanes are independent, so both can drive at once.
- R7: While `mode_hs` is high, both drives stay low regardless of the selects.
- R8: A lane whose drive is low presents all zeros on its bus.
- R9: While `cs_n` is high, both drives stay low regardless of the lane selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_load | input | 1 | Sequencer strobe that captures a new result |
| res_mag | input | 12 | Result magnitude |
| res_neg | input | 1 | Result sign flag |
| res_over | input | 1 | Result over-range flag |
| mode_hs | input | 1 | High selects the handshake mode, which disables direct reads |
| cs_n | input | 1 | Shared chip select, active low |
| hi_en_n | input | 1 | High-lane select, active low |
| lo_en_n | input | 1 | Low-lane select, active low |
| lo_bus | output | 8 | Low lane data |
| lo_drive | output | 1 | Low lane output enable |
| hi_bus | output | 8 | High lane data |
| hi_drive | output | 1 | High lane output enable |

## Verification
The bench aims at the following corner cases, each paired with the fault it would catch:

- **Swapped flag positions.** The stimulus sets and clears the sign and over-range flags separately, so a design that swaps the two flag bits shows the wrong bit lit. One that leaves the spare high bits floating shows stray ones.
- **Missing or shared gate.** The bench drives each lane alone and then both lanes together. A design that ignores the chip select or the mode pin drives the bus when it should not. A design that shares one gate between the lanes fails the single-lane cases.
- **Capture without the strobe.** Changing the result inputs with the strobe low exposes a holding register that captures without it.
- **Capture before the edge.** Looking at the bus just before the capture edge exposes a design that passes the new result through early.

// File: rtl/rbp_pkg.sv
package rbp_pkg;

   typedef enum logic [0:0] {
      LANE_LO = 1'b0,
      LANE_HI = 1'b1
   } lane_kind_e;

   // a select counts as asserted only on a definite low
   function automatic logic sel_asserted(input logic pin_n);
      return (pin_n == 1'b0);
   endfunction

endpackage

// File: rtl/rbp_hold.sv
module rbp_hold #(
   parameter int MAG_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAG_W-1:0] mag_d,
   input  logic             neg_d,
   input  logic             over_d,
   output logic [MAG_W-1:0] mag_q,
   output logic             neg_q,
   output logic             over_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag_q  <= '0;
         neg_q  <= 1'b0;
         over_q <= 1'b0;
      end else if (load) begin
         mag_q  <= mag_d;
         neg_q  <= neg_d;
         over_q <= over_d;
      end
   end

   assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (mag_q == $past(mag_d)) && (neg_q == $past(neg_d)) && (over_q == $past(over_d)));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(mag_q) && $stable(neg_q) && $stable(over_q));

endmodule

// File: rtl/rbp_pack.sv
module rbp_pack #(
   parameter int MAG_W  = 12,
   parameter int BYTE_W = 8
) (
   input  logic [MAG_W-1:0]  mag,
   input  logic              neg,
   input  logic              over,
   output logic [BYTE_W-1:0] lo_word,
   output logic [BYTE_W-1:0] hi_word
);

   localparam int HI_MAG_W = MAG_W - BYTE_W;
   localparam int OVER_POS = HI_MAG_W;
   localparam int NEG_POS  = HI_MAG_W + 1;

   generate
      if (HI_MAG_W < 1 || NEG_POS >= BYTE_W) begin : g_bad_geometry
         $error("rbp_pack: the high lane cannot hold the upper magnitude bits and both flags");
      end
   endgenerate

   always_comb begin
      lo_word = mag[BYTE_W-1:0];
      hi_word = '0;
      hi_word[HI_MAG_W-1:0] = mag[MAG_W-1:BYTE_W];
      hi_word[OVER_POS]     = over;
      hi_word[NEG_POS]      = neg;
   end

endmodule

// File: rtl/rbp_lane.sv
module rbp_lane
   import rbp_pkg::*;
#(
   parameter int         BYTE_W = 8,
   parameter lane_kind_e KIND   = LANE_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_hs,
   input  logic              cs_n,
   input  logic              en_n,
   input  logic [BYTE_W-1:0] payload,
   output logic [BYTE_W-1:0] bus,
   output logic              drive
);

   always_comb begin
      drive = !mode_hs && sel_asserted(cs_n) && sel_asserted(en_n);
      bus   = drive ? payload : '0;
   end

   generate
      if (KIND == LANE_HI) begin : g_hi_chk
         assert_hi_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !drive |-> (bus == '0));
      end else begin : g_lo_chk
         assert_lo_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !drive |-> (bus == '0));
      end
   endgenerate

endmodule

// File: rtl/rbp_read_port.sv
module rbp_read_port
   import rbp_pkg::*;
#(
   parameter int MAG_W  = 12,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              res_load,
   input  logic [MAG_W-1:0]  res_mag,
   input  logic              res_neg,
   input  logic              res_over,
   input  logic              mode_hs,
   input  logic              cs_n,
   input  logic              hi_en_n,
   input  logic              lo_en_n,
   output logic [BYTE_W-1:0] lo_bus,
   output logic              lo_drive,
   output logic [BYTE_W-1:0] hi_bus,
   output logic              hi_drive
);

   localparam int HI_MAG_W  = MAG_W - BYTE_W;
   localparam int SPARE_LSB = HI_MAG_W + 2;

   logic [MAG_W-1:0]  held_mag;
   logic              held_neg;
   logic              held_over;
   logic [BYTE_W-1:0] lo_word;
   logic [BYTE_W-1:0] hi_word;

   rbp_hold #(.MAG_W(MAG_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (res_load),
      .mag_d  (res_mag),
      .neg_d  (res_neg),
      .over_d (res_over),
      .mag_q  (held_mag),
      .neg_q  (held_neg),
      .over_q (held_over)
   );

   rbp_pack #(.MAG_W(MAG_W), .BYTE_W(BYTE_W)) u_pack (
      .mag     (held_mag),
      .neg     (held_neg),
      .over    (held_over),
      .lo_word (lo_word),
      .hi_word (hi_word)
   );

   rbp_lane #(.BYTE_W(BYTE_W), .KIND(LANE_LO)) u_lane_lo (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_hs (mode_hs),
      .cs_n    (cs_n),
      .en_n    (lo_en_n),
      .payload (lo_word),
      .bus     (lo_bus),
      .drive   (lo_drive)
   );

   rbp_lane #(.BYTE_W(BYTE_W), .KIND(LANE_HI)) u_lane_hi (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_hs (mode_hs),
      .cs_n    (cs_n),
      .en_n    (hi_en_n),
      .payload (hi_word),
      .bus     (hi_bus),
      .drive   (hi_drive)
   );

   assert_lo_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_drive |-> (!mode_hs && !cs_n && !lo_en_n));

   assert_hi_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hi_drive |-> (!mode_hs && !cs_n && !hi_en_n));

   assert_mode_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_hs |-> (!lo_drive && !hi_drive));

   assert_chip_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> (!lo_drive && !hi_drive));

   generate
      if (SPARE_LSB < BYTE_W) begin : g_spare_chk
         assert_hi_spare_R5: assert property (@(posedge clk) disable iff (!rst_n)
            hi_drive |-> (hi_bus[BYTE_W-1:SPARE_LSB] == '0));
      end
   endgenerate

endmodule

// File: tb/rbp_read_port_test.sv
module rbp_read_port_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        res_load = 1'b0;
   logic [11:0] res_mag = '0;
   logic        res_neg = 1'b0;
   logic        res_over = 1'b0;
   logic        mode_hs = 1'b0;
   logic        cs_n = 1'b1;
   logic        hi_en_n = 1'b1;
   logic        lo_en_n = 1'b1;
   logic [7:0]  lo_bus;
   logic        lo_drive;
   logic [7:0]  hi_bus;
   logic        hi_drive;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rbp_read_port uut (
      .clk(clk), .rst_n(rst_n), .res_load(res_load), .res_mag(res_mag),
      .res_neg(res_neg), .res_over(res_over), .mode_hs(mode_hs), .cs_n(cs_n),
      .hi_en_n(hi_en_n), .lo_en_n(lo_en_n), .lo_bus(lo_bus), .lo_drive(lo_drive),
      .hi_bus(hi_bus), .hi_drive(hi_drive)
   );

   // fields: mag[17:6] neg[5] over[4] mode[3] cs_n[2] hi_en_n[1] lo_en_n[0]
   localparam int NV = 8;
   localparam logic [17:0] VEC [NV] = '{
      {12'hA5C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      {12'h123, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      {12'h800, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
      {12'h3C3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
      {12'h000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
      {12'h7FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      {12'h5A5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected lane values from R4..R9
   task automatic expect_lanes(input string tag, input logic [11:0] m, input logic ng,
                               input logic ov, input logic md, input logic c,
                               input logic h, input logic l);
      logic el, eh;
      el = !md && !c && !l;
      eh = !md && !c && !h;
      chk({tag, " R6 lo_drive"}, {31'd0, lo_drive}, {31'd0, el});
      chk({tag, " R6 hi_drive"}, {31'd0, hi_drive}, {31'd0, eh});
      chk({tag, " R4/R8 lo_bus"}, {24'd0, lo_bus}, el ? {24'd0, m[7:0]} : 32'd0);
      chk({tag, " R5/R8 hi_bus"}, {24'd0, hi_bus},
          eh ? {24'd0, 2'b00, ng, ov, m[11:8]} : 32'd0);
   endtask

   task automatic load_word(input logic [11:0] m, input logic ng, input logic ov);
      @(negedge clk);
      res_mag = m; res_neg = ng; res_over = ov; res_load = 1'b1;
      @(negedge clk);
      res_load = 1'b0;
   endtask

   task automatic finish_run;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: chip select high after reset, nothing drives
      #1;
      chk("R9 reset lo_drive", {31'd0, lo_drive}, 32'd0);
      chk("R9 reset hi_drive", {31'd0, hi_drive}, 32'd0);
      // R1: read straight after reset returns zero
      cs_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
      #1;
      expect_lanes("R1 reset", 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      // vector table
      for (int i = 0; i < NV; i++) begin
         cs_n = 1'b1; hi_en_n = 1'b1; lo_en_n = 1'b1; mode_hs = 1'b0;
         load_word(VEC[i][17:6], VEC[i][5], VEC[i][4]);
         mode_hs = VEC[i][3]; cs_n = VEC[i][2]; hi_en_n = VEC[i][1]; lo_en_n = VEC[i][0];
         #1;
         expect_lanes($sformatf("R2 vec%0d", i), VEC[i][17:6], VEC[i][5], VEC[i][4],
                      VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      end

      // R3: inputs change without strobe, held value stays
      mode_hs = 1'b0; cs_n = 1'b0; hi_en_n = 1'b0; lo_en_n = 1'b0;
      load_word(12'h9E1, 1'b0, 1'b1);
      @(negedge clk);
      res_mag = 12'h16E; res_neg = 1'b1; res_over = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      expect_lanes("R3 no strobe", 12'h9E1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R2: new value not visible before the capture edge
      @(negedge clk);
      res_mag = 12'h4B7; res_neg = 1'b1; res_over = 1'b1; res_load = 1'b1;
      #1;
      expect_lanes("R2 before edge", 12'h9E1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      res_load = 1'b0;
      #1;
      expect_lanes("R2 after edge", 12'h4B7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);

      // R7: mode high overrides all selects
      mode_hs = 1'b1;
      #1;
      expect_lanes("R7 mode high", 12'h4B7, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

      // R9: chip select high with both lane selects low
      mode_hs = 1'b0; cs_n = 1'b1;
      #1;
      expect_lanes("R9 chip off", 12'h4B7, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

      // R6: lanes toggle independently
      cs_n = 1'b0; hi_en_n = 1'b1; lo_en_n = 1'b0;
      #1;
      expect_lanes("R6 lo only", 12'h4B7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
      hi_en_n = 1'b0; lo_en_n = 1'b1;
      #1;
      expect_lanes("R6 hi only", 12'h4B7, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);

      // R1: reset in mid-run clears the held word
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      lo_en_n = 1'b0;
      #1;
      expect_lanes("R1 re-reset", 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

      done = 1'b1;
      finish_run();
   end

endmodule